// File: doc/BRIEF.md
# Oscillator Register-Select Control with Optional Synchronizer

This block decides which frequency register (one of two) and which phase register (one of four) feed a numerically controlled oscillator. The choice comes either from dedicated select pins or from select bits that a serial control path has written. A small mode state machine holds two settings. The first says whether pins or bits are the source. The second says whether the selects and the destination-load event are retimed before use. A clear input returns the block to pin control with the retiming bypassed.

The retiming path matters because the select bits, the load toggle and the pins may all change with no fixed relation to the master clock. When retiming is on, the chosen selects and the load toggle are first captured on a rising master-clock edge. They then pass through two falling-edge stages, so every value is settled before the rising-edge logic uses it. The cost is two more cycles of latency.

A fixed alignment pipeline follows the source multiplexer. Its job is to make a select change appear at the registered outputs a set number of cycles later. Destination loads are signalled by toggling `load_tgl` once per transfer. The block turns each toggle into one single-cycle `load_stb` pulse.

Mode state machine states: `M_PIN_DIRECT` (pins, no retiming), `M_PIN_SYNC` (pins, retimed), `M_BIT_DIRECT` (bits, no retiming), `M_BIT_SYNC` (bits, retimed). Transitions: reset or `clr` goes to `M_PIN_DIRECT` from any state. Otherwise `ctl_wr` goes to the state encoded by {`ctl_sync`, `ctl_src`}. With neither, the state holds.

Top module: `regsel_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fsel_q`, `psel_q` and `load_stb` are all 0.
- R2: In a pin state, `fsel_q`/`psel_q` follow `pin_fsel`/`pin_psel`, and changes on `bit_fsel`/`bit_psel` have no effect on the outputs.
- R3: In a bit state, `fsel_q`/`psel_q` follow `bit_fsel`/`bit_psel`, and changes on the pins have no effect on the outputs. `psel_q` is the index 0 to 3 of the phase register and `fsel_q` is the index 0 or 1 of the frequency register.
- R4: `clr` forces the state `M_PIN_DIRECT` at the next rising edge and wins over a `ctl_wr` in the same cycle. Afterwards the pins drive with direct latency.
- R5: The mode changes only on a rising edge where `ctl_wr` or `clr` is high. Activity on `ctl_sync`/`ctl_src` without `ctl_wr` changes nothing.
- R6: With retiming off, a select input driven between edges appears at the outputs after exactly PIPE_DEPTH rising edges (6 by default).
- R7: With retiming on, the same change appears after exactly PIPE_DEPTH+2 rising edges (8 by default).
- R8: With retiming off, each change of `load_tgl` gives exactly one `load_stb` pulse, one cycle wide, visible after the first rising edge.
- R9: With retiming on, the `load_stb` pulse appears after the third rising edge and is still one cycle wide.
- R10: `ctl_wr` with `clr` low loads the state from {`ctl_sync`, `ctl_src`}: 00 `M_PIN_DIRECT`, 01 `M_BIT_DIRECT`, 10 `M_PIN_SYNC`, 11 `M_BIT_SYNC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Return to pin control with retiming bypassed |
| ctl_wr | input | 1 | Load the mode from `ctl_sync`/`ctl_src` |
| ctl_sync | input | 1 | Requested retiming setting |
| ctl_src | input | 1 | Requested source: 0 pins, 1 bits |
| pin_fsel | input | 1 | Frequency-register select pin |
| pin_psel | input | 2 | Phase-register select pins |
| bit_fsel | input | 1 | Frequency-register select bit |
| bit_psel | input | 2 | Phase-register select bits |
| load_tgl | input | 1 | Toggles once per destination transfer |
| fsel_q | output | 1 | Registered frequency-register select |
| psel_q | output | 2 | Registered phase-register select |
| load_stb | output | 1 | One-cycle destination load strobe |

## Verification
A state stuck in the wrong mode shows up at the outputs in one of two ways. A wrong retiming bit makes a select change arrive two edges early or late, six or eight cycles after the stimulus. The load strobe shifts between the first and third edge. A wrong source bit makes the outputs follow the ignored inputs within one pipeline depth, or fail to follow the selected ones. A clear that does not win over a same-cycle write leaves latency eight and bit control, both visible within eight cycles.

// File: rtl/regsel_pkg.sv
package regsel_pkg;

    localparam int FSEL_W = 1;
    localparam int PSEL_W = 2;

    typedef struct packed {
        logic [FSEL_W-1:0] fsel;
        logic [PSEL_W-1:0] psel;
    } sel_t;

    localparam int SEL_W = $bits(sel_t);

    typedef enum logic [1:0] {
        M_PIN_DIRECT = 2'b00,
        M_BIT_DIRECT = 2'b01,
        M_PIN_SYNC   = 2'b10,
        M_BIT_SYNC   = 2'b11
    } mode_e;

endpackage

// File: rtl/regsel_mode_fsm.sv
module regsel_mode_fsm
    import regsel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ctl_wr,
    input  logic ctl_sync,
    input  logic ctl_src,
    output logic use_bits,
    output logic use_sync
);

    mode_e state_q, state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = M_PIN_DIRECT;
        end else if (ctl_wr) begin
            unique case ({ctl_sync, ctl_src})
                2'b00: state_d = M_PIN_DIRECT;
                2'b01: state_d = M_BIT_DIRECT;
                2'b10: state_d = M_PIN_SYNC;
                2'b11: state_d = M_BIT_SYNC;
            endcase
        end
    end

    // state register: rising edge only, so the path mux never switches mid-cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= M_PIN_DIRECT;
        else        state_q <= state_d;
    end

    // decoded controls
    always_comb begin
        use_bits = 1'b0;
        use_sync = 1'b0;
        unique case (state_q)
            M_PIN_DIRECT: begin use_bits = 1'b0; use_sync = 1'b0; end
            M_BIT_DIRECT: begin use_bits = 1'b1; use_sync = 1'b0; end
            M_PIN_SYNC:   begin use_bits = 1'b0; use_sync = 1'b1; end
            M_BIT_SYNC:   begin use_bits = 1'b1; use_sync = 1'b1; end
        endcase
    end

    p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ctl_wr) |=> $stable(state_q));

    p_clr_default_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!use_bits && !use_sync));

    p_write_loads_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !clr) |=> (use_sync == $past(ctl_sync) && use_bits == $past(ctl_src)));

endmodule

// File: rtl/regsel_sync2.sv
module regsel_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] rt_q;
    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    // retime to the rising edge first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rt_q <= '0;
        else        rt_q <= d;
    end

    // two falling-edge stages settle the value before the next rising edge uses it
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= rt_q;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;

endmodule

// File: rtl/regsel_align.sv
module regsel_align #(
    parameter int W     = 3,
    parameter int DEPTH = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= d;
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[DEPTH-1];

endmodule

// File: rtl/regsel_ctrl.sv
module regsel_ctrl
    import regsel_pkg::*;
#(
    parameter int PIPE_DEPTH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ctl_wr,
    input  logic              ctl_sync,
    input  logic              ctl_src,
    input  logic              pin_fsel,
    input  logic [PSEL_W-1:0] pin_psel,
    input  logic              bit_fsel,
    input  logic [PSEL_W-1:0] bit_psel,
    input  logic              load_tgl,
    output logic              fsel_q,
    output logic [PSEL_W-1:0] psel_q,
    output logic              load_stb
);

    localparam int XW = SEL_W + 1;   // selects plus load toggle

    logic use_bits, use_sync;
    sel_t pin_sel, bit_sel, src_sel, chosen, aligned;
    logic [XW-1:0] sync_out;
    logic tgl_sample, tgl_prev_q;
    logic [1:0] warm_q;

    regsel_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .ctl_wr   (ctl_wr),
        .ctl_sync (ctl_sync),
        .ctl_src  (ctl_src),
        .use_bits (use_bits),
        .use_sync (use_sync)
    );

    assign pin_sel = '{fsel: pin_fsel, psel: pin_psel};
    assign bit_sel = '{fsel: bit_fsel, psel: bit_psel};
    assign src_sel = use_bits ? bit_sel : pin_sel;

    regsel_sync2 #(.W(XW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({load_tgl, src_sel}),
        .q     (sync_out)
    );

    // one mux picks the direct or retimed copy; both copies run continuously
    assign chosen     = use_sync ? sel_t'(sync_out[SEL_W-1:0]) : src_sel;
    assign tgl_sample = use_sync ? sync_out[XW-1] : load_tgl;

    regsel_align #(.W(SEL_W), .DEPTH(PIPE_DEPTH)) u_align (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (chosen),
        .q     (aligned)
    );

    assign fsel_q = aligned.fsel;
    assign psel_q = aligned.psel;

    // toggle-to-pulse conversion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgl_prev_q <= 1'b0;
            load_stb   <= 1'b0;
        end else begin
            tgl_prev_q <= tgl_sample;
            load_stb   <= tgl_sample ^ tgl_prev_q;
        end
    end

    // cycles since reset, for assertions that look two cycles back
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    p_stb_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3 && load_stb && !$past(use_sync) && !$past(use_sync, 2))
            |-> ($past(load_tgl) != $past(load_tgl, 2)));

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd0) |-> (!load_stb && !fsel_q && psel_q == '0));

endmodule

// File: tb/tb_regsel_ctrl.sv
`timescale 1ns/1ps
module tb_regsel_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0, ctl_wr = 1'b0, ctl_sync = 1'b0, ctl_src = 1'b0;
    logic pin_fsel = 1'b0, bit_fsel = 1'b0, load_tgl = 1'b0;
    logic [1:0] pin_psel = 2'b00, bit_psel = 2'b00;
    logic fsel_q, load_stb;
    logic [1:0] psel_q;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    regsel_ctrl dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ctl_wr(ctl_wr),
        .ctl_sync(ctl_sync), .ctl_src(ctl_src),
        .pin_fsel(pin_fsel), .pin_psel(pin_psel),
        .bit_fsel(bit_fsel), .bit_psel(bit_psel),
        .load_tgl(load_tgl), .fsel_q(fsel_q), .psel_q(psel_q),
        .load_stb(load_stb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (14) @(posedge clk);
    endtask

    task automatic edge_drive();
        @(posedge clk);
        #2;
    endtask

    // counts rising edges until the outputs show the wanted selects
    task automatic measure_sel(input logic f, input logic [1:0] p, input int exp_lat, input string req);
        int lat = 0;
        for (int k = 1; k <= 14; k++) begin
            @(posedge clk); #1;
            if (lat == 0 && fsel_q == f && psel_q == p) lat = k;
        end
        chk(lat == exp_lat, req, lat, exp_lat);
    endtask

    task automatic expect_hold(input logic f, input logic [1:0] p, input string req);
        settle();
        #1;
        chk(fsel_q == f && psel_q == p, req, {fsel_q, psel_q}, {f, p});
    endtask

    task automatic measure_stb(input int exp_lat, input string req);
        int lat = 0;
        int cnt = 0;
        edge_drive();
        load_tgl = ~load_tgl;
        for (int k = 1; k <= 8; k++) begin
            @(posedge clk); #1;
            if (load_stb) begin
                cnt++;
                if (lat == 0) lat = k;
            end
        end
        chk(lat == exp_lat, {req, " latency"}, lat, exp_lat);
        chk(cnt == 1, {req, " width"}, cnt, 1);
    endtask

    task automatic wr_ctl(input logic s, input logic b, input logic with_clr);
        edge_drive();
        ctl_wr = 1'b1; ctl_sync = s; ctl_src = b; clr = with_clr;
        edge_drive();
        ctl_wr = 1'b0; clr = 1'b0;
        settle();
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        chk(fsel_q == 1'b0 && psel_q == 2'b00 && load_stb == 1'b0, "R1 in reset",
            {fsel_q, psel_q, load_stb}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(fsel_q == 1'b0 && psel_q == 2'b00 && load_stb == 1'b0, "R1 after release",
            {fsel_q, psel_q, load_stb}, 0);
        settle();
    endtask

    task automatic t_pin_direct();
        edge_drive(); pin_fsel = 1'b1; pin_psel = 2'b10;
        measure_sel(1'b1, 2'b10, 6, "R6 R2 pin fsel+psel direct");
        edge_drive(); pin_psel = 2'b11;
        measure_sel(1'b1, 2'b11, 6, "R6 R2 pin psel direct");
        edge_drive(); bit_fsel = 1'b0; bit_psel = 2'b01;
        expect_hold(1'b1, 2'b11, "R2 bits ignored in pin state");
    endtask

    task automatic t_hold_mode();
        edge_drive(); ctl_sync = 1'b1; ctl_src = 1'b1;
        settle();
        edge_drive(); pin_fsel = 1'b0;
        measure_sel(1'b0, 2'b11, 6, "R5 controls without write ignored");
    endtask

    task automatic t_bit_direct();
        wr_ctl(1'b0, 1'b1, 1'b0);
        #1;
        chk(fsel_q == 1'b0 && psel_q == 2'b01, "R10 R3 switch to M_BIT_DIRECT",
            {fsel_q, psel_q}, 1);
        edge_drive(); bit_fsel = 1'b1; bit_psel = 2'b00;
        measure_sel(1'b1, 2'b00, 6, "R3 R6 bit select direct");
        edge_drive(); pin_fsel = 1'b1; pin_psel = 2'b01;
        expect_hold(1'b1, 2'b00, "R3 pins ignored in bit state");
    endtask

    task automatic t_bit_sync();
        wr_ctl(1'b1, 1'b1, 1'b0);
        edge_drive(); bit_psel = 2'b11;
        measure_sel(1'b1, 2'b11, 8, "R7 R10 M_BIT_SYNC latency");
        measure_stb(3, "R9 strobe retimed");
    endtask

    task automatic t_pin_sync();
        wr_ctl(1'b1, 1'b0, 1'b0);
        #1;
        chk(fsel_q == 1'b1 && psel_q == 2'b01, "R10 switch to M_PIN_SYNC",
            {fsel_q, psel_q}, 5);
        edge_drive(); pin_fsel = 1'b0; pin_psel = 2'b10;
        measure_sel(1'b0, 2'b10, 8, "R7 pin select retimed");
    endtask

    task automatic t_clr();
        wr_ctl(1'b1, 1'b1, 1'b0);
        wr_ctl(1'b1, 1'b1, 1'b1);   // clear and write in the same cycle
        #1;
        chk(fsel_q == 1'b0 && psel_q == 2'b10, "R4 clear selects pins",
            {fsel_q, psel_q}, 2);
        edge_drive(); pin_psel = 2'b01;
        measure_sel(1'b0, 2'b01, 6, "R4 clear restores direct latency");
        edge_drive(); bit_fsel = 1'b0; bit_psel = 2'b10;
        expect_hold(1'b0, 2'b01, "R4 bits ignored after clear");
        measure_stb(1, "R4 R8 strobe direct after clear");
    endtask

    initial begin
        t_reset();
        t_pin_direct();
        measure_stb(1, "R8 strobe direct");
        measure_stb(1, "R8 strobe direct second toggle");
        t_hold_mode();
        t_bit_direct();
        t_bit_sync();
        t_pin_sync();
        t_clr();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(1_000_000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule